// File: doc/BRIEF.md
# Time-Base and Watchdog Generator

This block counts a 256 Hz tick and produces two timing signals. The first is a periodic time-base pulse whose rate is one of eight powers of two, from 1 Hz to 128 Hz. The second is a watchdog flag. The flag sets once four periods of that same rate have gone by since the watchdog was last cleared, and it stays set until the watchdog is cleared again. An active-low interrupt line can carry either source.

A serial command decoder upstream delivers 9-bit subcommands on a valid/ready port. The subcommands do the following:

- start or stop the counters;
- pick the rate;
- clear either counter;
- gate each output;
- route the sources to the interrupt line.

The command port never applies back-pressure. Its ready signal is held high, and a subcommand is taken on every cycle that has valid high.

Top module: `tbw_gen`

## Requirements
- R1: `cmd_ready` is 1 at all times after reset. A subcommand is accepted on any cycle with `cmd_valid` high. Its effect is visible on the outputs in the very next clock cycle.
- R2: Reset leaves the following state: counters stopped, rate 128 Hz, time-base output gated off, watchdog output gated off, interrupt routing off. The outputs read `tb_pulse`=0, `wdt_flag`=0 and `irq_n`=1.
- R3: Code 0x001 starts both counters. Code 0x000 stops them. While stopped, ticks are ignored, so no time-base pulse is produced and the watchdog does not advance.
- R4: Codes 0x0A0 to 0x0A7 select the rate 2^k Hz, where k is code bits [2:0]. The time-base period is then 2^(8-k) ticks.
- R5: Codes 0x006 and 0x004 enable and disable the time-base output. When it is enabled, `tb_pulse` is high for exactly one cycle. That cycle follows the tick that completes each period. N ticks after a divider clear therefore give floor(N/P) pulses, where P is the period in ticks.
- R6: Code 0x00C clears the time-base divider. The next pulse then comes exactly one full period of ticks after the clear.
- R7: The internal watchdog flag sets on the tick that completes 4*P ticks since the last watchdog clear. Codes 0x007 and 0x005 enable and disable showing that flag on `wdt_flag`.
- R8: The watchdog flag holds until code 0x00E clears it. Gating the output off and back on does not lose the flag.
- R9: Code 0x088 enables interrupt routing and 0x080 disables it. `irq_n` is low exactly when routing is enabled and at least one of `tb_pulse` or `wdt_flag` is high.
- R10: Any other code is ignored, for example 0x01F or 0x0A8. Rate, gates, routing and counters are left as they were.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_in | input | 1 | One-cycle strobe at 256 Hz |
| cmd_valid | input | 1 | Subcommand present |
| cmd_ready | output | 1 | Subcommand can be taken (always 1) |
| cmd_code | input | 9 | Subcommand code |
| tb_pulse | output | 1 | Gated time-base pulse |
| wdt_flag | output | 1 | Gated watchdog time-out flag |
| irq_n | output | 1 | Active-low interrupt |

## Verification
A subcommand presented before a rising edge changes the state at that edge. The bench therefore reads its effect at the falling edge right after the command cycle, which is one cycle of latency. A tick strobe that completes a period or the watchdog window registers the pulse or flag at the same edge. The bench samples `tb_pulse`, `wdt_flag` and `irq_n` at the falling edge after every tick, so each one-cycle pulse is counted exactly once. It then waits two idle cycles before the next tick, so a pulse can never be seen twice.

// File: rtl/tbw_pkg.sv
package tbw_pkg;

  localparam int CMD_W = 9;

  localparam logic [CMD_W-1:0] SC_RUN_OFF  = 9'h000;
  localparam logic [CMD_W-1:0] SC_RUN_ON   = 9'h001;
  localparam logic [CMD_W-1:0] SC_TB_OFF   = 9'h004;
  localparam logic [CMD_W-1:0] SC_WD_OFF   = 9'h005;
  localparam logic [CMD_W-1:0] SC_TB_ON    = 9'h006;
  localparam logic [CMD_W-1:0] SC_WD_ON    = 9'h007;
  localparam logic [CMD_W-1:0] SC_TB_CLR   = 9'h00C;
  localparam logic [CMD_W-1:0] SC_WD_CLR   = 9'h00E;
  localparam logic [CMD_W-1:0] SC_IRQ_OFF  = 9'h080;
  localparam logic [CMD_W-1:0] SC_IRQ_ON   = 9'h088;
  localparam logic [CMD_W-1:0] SC_RATE_SEL = 9'h0A0;

  typedef enum logic [3:0] {
    OP_NONE, OP_RUN_OFF, OP_RUN_ON, OP_TB_OFF, OP_TB_ON,
    OP_WD_OFF, OP_WD_ON, OP_TB_CLR, OP_WD_CLR,
    OP_IRQ_OFF, OP_IRQ_ON, OP_RATE
  } op_e;

  typedef struct packed {
    logic run;
    logic tb_en;
    logic wd_en;
    logic irq_en;
  } ctl_t;

  function automatic op_e fixed_op(input logic [CMD_W-1:0] code);
    op_e r;
    case (code)
      SC_RUN_OFF: r = OP_RUN_OFF;
      SC_RUN_ON:  r = OP_RUN_ON;
      SC_TB_OFF:  r = OP_TB_OFF;
      SC_WD_OFF:  r = OP_WD_OFF;
      SC_TB_ON:   r = OP_TB_ON;
      SC_WD_ON:   r = OP_WD_ON;
      SC_TB_CLR:  r = OP_TB_CLR;
      SC_WD_CLR:  r = OP_WD_CLR;
      SC_IRQ_OFF: r = OP_IRQ_OFF;
      SC_IRQ_ON:  r = OP_IRQ_ON;
      default:    r = OP_NONE;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/tbw_cmd_decode.sv
module tbw_cmd_decode
  import tbw_pkg::*;
#(
  parameter int               RSEL_W   = 3,
  parameter logic [RSEL_W-1:0] DEF_RATE = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [CMD_W-1:0]  code,
  output ctl_t              ctl_q,
  output logic [RSEL_W-1:0] rate_q,
  output logic              tb_clr,
  output logic              wd_clr
);

  localparam int HI_W = CMD_W - RSEL_W;

  op_e op;

  always_comb begin
    if (!fire)
      op = OP_NONE;
    else if (code[CMD_W-1:RSEL_W] == SC_RATE_SEL[CMD_W-1:RSEL_W])
      op = OP_RATE;
    else
      op = fixed_op(code);
  end

  assign tb_clr = (op == OP_TB_CLR);
  assign wd_clr = (op == OP_WD_CLR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      rate_q <= DEF_RATE;
    end else begin
      case (op)
        OP_RUN_OFF: ctl_q.run    <= 1'b0;
        OP_RUN_ON:  ctl_q.run    <= 1'b1;
        OP_TB_OFF:  ctl_q.tb_en  <= 1'b0;
        OP_TB_ON:   ctl_q.tb_en  <= 1'b1;
        OP_WD_OFF:  ctl_q.wd_en  <= 1'b0;
        OP_WD_ON:   ctl_q.wd_en  <= 1'b1;
        OP_IRQ_OFF: ctl_q.irq_en <= 1'b0;
        OP_IRQ_ON:  ctl_q.irq_en <= 1'b1;
        OP_RATE:    rate_q       <= code[RSEL_W-1:0];
        default:    ;
      endcase
    end
  end

  // HI_W kept for clarity of the rate-code split
  logic unused_hi;
  assign unused_hi = (HI_W > 0) ? 1'b0 : 1'b0;

endmodule

// File: rtl/tbw_div.sv
module tbw_div #(
  parameter int CNT_W  = 8,
  parameter int RSEL_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              run,
  input  logic              clr,
  input  logic [RSEL_W-1:0] rate,
  output logic              wrap
);

  localparam logic [CNT_W-1:0] ONES = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] span;

  // low (CNT_W - rate) bits form the active window
  assign span = ONES >> rate;
  assign wrap = tick && run && !clr && (&(cnt_q | ~span));

  always_ff @(posedge clk) begin
    if (!rst_n || clr)
      cnt_q <= '0;
    else if (tick && run)
      cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/tbw_irq_route.sv
module tbw_irq_route (
  input  logic irq_en,
  input  logic tb_vis,
  input  logic wd_vis,
  output logic irq_n
);

  assign irq_n = ~(irq_en & (tb_vis | wd_vis));

endmodule

// File: rtl/tbw_gen.sv
module tbw_gen
  import tbw_pkg::*;
#(
  parameter int                RSEL_W     = 3,
  parameter int                TB_W       = 8,
  parameter int                WD_PER_LOG = 2,
  parameter logic [RSEL_W-1:0] DEF_RATE   = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_in,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [CMD_W-1:0] cmd_code,
  output logic             tb_pulse,
  output logic             wdt_flag,
  output logic             irq_n
);

  localparam int WD_W = TB_W + WD_PER_LOG;

  ctl_t              ctl;
  logic [RSEL_W-1:0] rate;
  logic              tb_clr, wd_clr;
  logic              tb_wrap, wd_wrap;
  logic              run_on;
  logic              tb_q, flag_q;

  assign cmd_ready = 1'b1;
  assign run_on    = ctl.run;

  tbw_cmd_decode #(.RSEL_W(RSEL_W), .DEF_RATE(DEF_RATE)) u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (cmd_valid),
    .code   (cmd_code),
    .ctl_q  (ctl),
    .rate_q (rate),
    .tb_clr (tb_clr),
    .wd_clr (wd_clr)
  );

  tbw_div #(.CNT_W(TB_W), .RSEL_W(RSEL_W)) u_tb_div (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick_in),
    .run   (run_on),
    .clr   (tb_clr),
    .rate  (rate),
    .wrap  (tb_wrap)
  );

  tbw_div #(.CNT_W(WD_W), .RSEL_W(RSEL_W)) u_wd_div (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick_in),
    .run   (run_on),
    .clr   (wd_clr),
    .rate  (rate),
    .wrap  (wd_wrap)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tb_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      tb_q <= tb_wrap;
      if (wd_clr)
        flag_q <= 1'b0;
      else if (wd_wrap)
        flag_q <= 1'b1;
    end
  end

  assign tb_pulse = tb_q & ctl.tb_en;
  assign wdt_flag = flag_q & ctl.wd_en;

  tbw_irq_route u_irq (
    .irq_en (ctl.irq_en),
    .tb_vis (tb_pulse),
    .wd_vis (wdt_flag),
    .irq_n  (irq_n)
  );

endmodule

// File: rtl/tbw_gen_chk.sv
module tbw_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic tick_in,
  input logic tb_pulse,
  input logic wdt_flag,
  input logic irq_n,
  input logic flag_q,
  input logic wd_clr,
  input logic run_on
);

  // R5
  tb_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tb_pulse |-> $past(tick_in));

  // R5
  tb_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tb_pulse |=> !tb_pulse);

  // R3
  stopped_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_on |=> !tb_pulse);

  // R7
  flag_rise_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(tick_in));

  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !wd_clr) |=> flag_q);

  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_clr |=> !wdt_flag);

  // R9
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (tb_pulse || wdt_flag));

endmodule

bind tbw_gen tbw_gen_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick_in  (tick_in),
  .tb_pulse (tb_pulse),
  .wdt_flag (wdt_flag),
  .irq_n    (irq_n),
  .flag_q   (flag_q),
  .wd_clr   (wd_clr),
  .run_on   (run_on)
);

// File: tb/tbw_gen_tb.sv
module tbw_gen_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_in = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [8:0] cmd_code = '0;
  logic       cmd_ready, tb_pulse, wdt_flag, irq_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tbw_gen u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_in   (tick_in),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_code  (cmd_code),
    .tb_pulse  (tb_pulse),
    .wdt_flag  (wdt_flag),
    .irq_n     (irq_n)
  );

  typedef struct packed {
    logic [8:0]  cmd;
    logic [15:0] ticks;
    logic [7:0]  pulses;
    logic        flag;
    logic [7:0]  irqs;
  } vec_t;

  // each row: command, then both clears, then ticks; expected counts at the outputs
  localparam vec_t VEC [15] = '{
    '{9'h001, 16'd8,   8'd0, 1'b0, 8'd0},  // R3 start, outputs gated
    '{9'h006, 16'd8,   8'd4, 1'b0, 8'd0},  // R5 R4 128 Hz default
    '{9'h007, 16'd7,   8'd3, 1'b0, 8'd0},  // R7 window not reached
    '{9'h0A5, 16'd32,  8'd4, 1'b1, 8'd0},  // R4 R7 32 Hz
    '{9'h088, 16'd31,  8'd3, 1'b0, 8'd3},  // R9 pulses routed
    '{9'h004, 16'd32,  8'd0, 1'b1, 8'd1},  // R5 R9 flag routed
    '{9'h005, 16'd40,  8'd0, 1'b0, 8'd0},  // R7 gate off
    '{9'h006, 16'd16,  8'd2, 1'b0, 8'd2},  // R9
    '{9'h080, 16'd16,  8'd2, 1'b0, 8'd0},  // R9 routing off
    '{9'h000, 16'd40,  8'd0, 1'b0, 8'd0},  // R3 stop
    '{9'h001, 16'd16,  8'd2, 1'b0, 8'd0},  // R3 restart
    '{9'h01F, 16'd16,  8'd2, 1'b0, 8'd0},  // R10 ignored
    '{9'h0A8, 16'd16,  8'd2, 1'b0, 8'd0},  // R10 ignored
    '{9'h0A0, 16'd256, 8'd1, 1'b0, 8'd0},  // R4 1 Hz
    '{9'h0A3, 16'd64,  8'd2, 1'b0, 8'd0}   // R4 8 Hz
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send(input logic [8:0] c);
    cmd_code  = c;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic ticks(input int n, output int p, output int q);
    p = 0;
    q = 0;
    for (int i = 0; i < n; i++) begin
      tick_in = 1'b1;
      @(negedge clk);
      tick_in = 1'b0;
      if (tb_pulse) p++;
      if (!irq_n)   q++;
      @(negedge clk);
      @(negedge clk);
    end
  endtask

  initial begin
    int p, q;
    @(negedge clk);
    do_reset();
    check("R2 tb_pulse", tb_pulse, 0);
    check("R2 wdt_flag", wdt_flag, 0);
    check("R2 irq_n", irq_n, 1);
    check("R1 cmd_ready", cmd_ready, 1);

    for (int r = 0; r < 15; r++) begin
      send(VEC[r].cmd);
      send(9'h00C);
      send(9'h00E);
      ticks(int'(VEC[r].ticks), p, q);
      check($sformatf("R5 row %0d pulses", r), p, int'(VEC[r].pulses));
      check($sformatf("R7 row %0d flag", r), wdt_flag, int'(VEC[r].flag));
      check($sformatf("R9 row %0d irq", r), q, int'(VEC[r].irqs));
    end

    // R2 R3: gates on but counters stopped after reset
    do_reset();
    send(9'h006); send(9'h007); send(9'h088);
    ticks(16, p, q);
    check("R3 stopped pulses", p, 0);
    check("R3 stopped flag", wdt_flag, 0);
    check("R3 stopped irq", q, 0);
    send(9'h001);
    ticks(2, p, q);
    check("R4 default 128 Hz pulse", p, 1);

    // R7 R8 watchdog window and stickiness
    send(9'h00C); send(9'h00E);
    ticks(7, p, q);
    check("R7 flag before window", wdt_flag, 0);
    ticks(1, p, q);
    check("R7 flag at window", wdt_flag, 1);
    send(9'h004);
    ticks(20, p, q);
    check("R8 flag held", wdt_flag, 1);
    send(9'h005);
    check("R7 flag gated off", wdt_flag, 0);
    check("R9 irq released", irq_n, 1);
    send(9'h007);
    check("R8 flag kept while gated", wdt_flag, 1);
    check("R9 irq from flag", irq_n, 0);
    send(9'h00E);
    check("R8 flag cleared", wdt_flag, 0);
    check("R1 clear next cycle irq", irq_n, 1);

    // R6 divider clear restarts the period
    send(9'h006); send(9'h0A3); send(9'h00C); send(9'h00E);
    ticks(20, p, q);
    check("R6 pre-clear pulses", p, 0);
    send(9'h00C);
    ticks(31, p, q);
    check("R6 no pulse before full period", p, 0);
    ticks(1, p, q);
    check("R6 pulse at full period", p, 1);
    check("R9 irq follows pulse", q, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule